// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Slave Select

This block moves one 8-bit byte at a time over a clocked serial link, least significant bit first. In master mode it generates the transfer clock itself by dividing the system clock. In slave mode it takes the transfer clock and an active-low slave-select from outside. The core logic asks for a transfer with a start pulse and a parallel byte. It watches a busy flag and takes the received byte when a one-cycle done pulse appears.

A polarity input sets the level at which the serial clock rests. A phase input sets which clock edge launches data and which edge captures it. Both ends of a link must use the same pair of settings. The leading edge is the first edge that leaves the rest level, and the trailing edge is the one that returns to it. With phase set, the first bit is on the data line as soon as the transfer starts. Capture then happens on leading edges. With phase clear, the data line carries no defined bit until the first leading edge. Capture then happens on trailing edges.

In slave mode the data output is released, with its enable low, whenever slave-select is high. The select and clock pins go through a two-stage synchronizer. The system clock must therefore run at least four times as fast as the serial clock.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, busy_o, done_o and rx_data_o are all zero, and sclk_o is low while clk_pol_i is 0.
- R2: In master mode the serial clock toggles every div_i system cycles during a transfer, and a div_i below 2 acts as 2. There are exactly 16 toggles per transfer, the first one div_i cycles after the start pulse is taken. Outside a transfer sclk_o rests at clk_pol_i, so 0 means it rests low and 1 means it rests high.
- R3: Bit 0 of tx_data_i goes out first and bit 7 goes out last. The first received bit lands in bit 0 of rx_data_o.
- R4: With phase_i = 1, bit 0 is driven when the transfer starts. Bits are captured on leading edges, and the next bit is launched on each trailing edge.
- R5: With phase_i = 0, each bit is launched on a leading edge and captured on the following trailing edge.
- R6: done_o is a one-cycle pulse raised with the eighth capture, and rx_data_o changes only together with it. In master mode, counting from the clock edge that takes start_i, done_o follows edge 16·div_i (phase 0) or edge 15·div_i (phase 1). busy_o falls after edge 16·div_i+1.
- R7: A start pulse that arrives while a master transfer is busy is ignored. The clock timing and the transmitted byte are left unchanged.
- R8: In slave mode sdo_oe_o is 0 whenever ss_n_i is high, with no clock delay. It is 1 while ss_n_i is low, and it is always 1 in master mode.
- R9: In slave mode the block reacts on the third system clock edge after a change on ss_n_i or sclk_i. busy_o rises then after a select fall, and done_o follows the final capturing pin edge by that same count.
- R10: If ss_n_i rises in the middle of a byte, the slave drops busy_o without raising done_o. The next selection starts again from bit 0.
- R11: While ss_n_i is high, the slave ignores activity on sclk_i. busy_o, done_o and rx_data_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 0 = master with internal clock, 1 = slave with external clock |
| clk_pol_i | input | 1 | Rest level of the serial clock |
| phase_i | input | 1 | 1 = bit 0 driven at start and capture on leading edges; 0 = launch on leading edges and capture on trailing edges |
| div_i | input | DIV_W | Half-period of the master clock in system cycles |
| start_i | input | 1 | Master transfer request |
| tx_data_i | input | DATA_W | Byte to send, taken when the transfer starts |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the byte is complete |
| rx_data_o | output | DATA_W | Last byte received |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Slave select, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 = released |
| sdi_i | input | 1 | Serial data in |

## Verification
In master mode the bench advances a behavioural counter from the edge that takes start_i. On every falling system edge it predicts sclk_o as the rest level flipped by min(t/div,16) toggles, busy_o as high up to t = 16·div, and done_o at t = 16·div or 15·div. Each of these is compared in that exact cycle. In slave mode the bench drives pins at falling edges. It expects busy_o three edges after the select fall and done_o three edges after the last capturing pin edge. Serial bits are read half a serial period after each launch, well past the three-cycle latency. Release of the output enable is read one cycle after ss_n_i rises.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic lead;
    logic trail;
  } sclk_evt_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[g-1].q;
    end
  end
  assign sync_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen import ssp_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pol_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output sclk_evt_t        evt_o,
  output logic             fin_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int ECW   = $clog2(EDGES + 1);
  localparam logic [ECW-1:0] EDGE_LAST = ECW'(EDGES);

  logic [DIV_W-1:0] div_q, lim;
  logic [ECW-1:0]   ecnt_q;
  logic             sclk_q, tick;

  // half-period never shorter than two system cycles
  assign lim  = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);
  assign tick = run_i && (div_q == lim) && (ecnt_q != EDGE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      div_q  <= '0;
      ecnt_q <= '0;
    end else if (!run_i) begin
      sclk_q <= pol_i;
      div_q  <= '0;
      ecnt_q <= '0;
    end else if (div_q == lim) begin
      div_q <= '0;
      if (ecnt_q != EDGE_LAST) begin
        sclk_q <= ~sclk_q;
        ecnt_q <= ecnt_q + ECW'(1);
      end
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  assign sclk_o      = sclk_q;
  assign evt_o.lead  = tick && (sclk_q == pol_i);
  assign evt_o.trail = tick && (sclk_q != pol_i);
  assign fin_o       = run_i && (ecnt_q == EDGE_LAST);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift import ssp_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              abort_i,
  input  logic              phase_i,
  input  sclk_evt_t         evt_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              active_o,
  output logic              done_o,
  output logic              sdo_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int IW = $clog2(DATA_W);
  localparam logic [IW-1:0] LAST = IW'(DATA_W - 1);

  logic [IW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_q, rx_sh_q, rx_q, rx_next;
  logic              act_q, done_q, sdo_q, launch, capture;

  assign launch  = phase_i ? evt_i.trail : evt_i.lead;
  assign capture = phase_i ? evt_i.lead  : evt_i.trail;
  assign rx_next = {sdi_i, rx_sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      sdo_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (begin_i) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        tx_q  <= tx_i;
        if (phase_i) sdo_q <= tx_i[0];
      end else if (act_q) begin
        if (capture) begin
          rx_sh_q <= rx_next;
          cnt_q   <= cnt_q + IW'(1);
          if (cnt_q == LAST) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= rx_next;
          end
        end
        if (launch) sdo_q <= tx_q[cnt_q];
      end
    end
  end

  assign active_o = act_q;
  assign done_o   = done_q;
  assign sdo_o    = sdo_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port import ssp_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              clk_pol_i,
  input  logic              phase_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  input  logic              sclk_i,
  input  logic              ss_n_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdi_i
);
  // pin vector: [1] select, [0] clock
  logic [1:0] pin_s, pin_p;
  logic       ss_fall, ss_rise, sck_chg;
  logic       m_run_q, m_start, gen_fin, eng_act, eng_begin, eng_abort;
  sclk_evt_t  slv_evt, gen_evt, eng_evt;

  ssp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ss_n_i, sclk_i}),
    .sync_o  (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pin_p <= 2'b10;
    else         pin_p <= pin_s;

  assign ss_fall       = pin_p[1] & ~pin_s[1];
  assign ss_rise       = ~pin_p[1] & pin_s[1];
  assign sck_chg       = pin_p[0] ^ pin_s[0];
  assign slv_evt.lead  = sck_chg & (pin_p[0] == clk_pol_i);
  assign slv_evt.trail = sck_chg & (pin_p[0] != clk_pol_i);

  assign m_start = start_i & ~slave_mode_i & ~m_run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      m_run_q <= 1'b0;
    else if (m_start) m_run_q <= 1'b1;
    else if (gen_fin) m_run_q <= 1'b0;

  ssp_clkgen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (m_run_q),
    .pol_i  (clk_pol_i),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .evt_o  (gen_evt),
    .fin_o  (gen_fin)
  );

  assign eng_evt   = slave_mode_i ? slv_evt : gen_evt;
  assign eng_begin = slave_mode_i ? ss_fall : m_start;
  assign eng_abort = slave_mode_i & ss_rise;

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .begin_i  (eng_begin),
    .abort_i  (eng_abort),
    .phase_i  (phase_i),
    .evt_i    (eng_evt),
    .sdi_i    (sdi_i),
    .tx_i     (tx_data_i),
    .active_o (eng_act),
    .done_o   (done_o),
    .sdo_o    (sdo_o),
    .rx_o     (rx_data_o)
  );

  assign busy_o   = slave_mode_i ? eng_act : m_run_q;
  // raw pin, so release needs no clock
  assign sdo_oe_o = ~slave_mode_i | ~ss_n_i;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_mode_i,
  input logic              clk_pol_i,
  input logic              ss_n_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              sclk_o,
  input logic              sdo_oe_o
);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));

  assert_rx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_data_o));

  assert_slave_done_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && done_o) |-> !busy_o);

  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !busy_o && !$past(busy_o) && $stable(clk_pol_i) && $past(rst_ni))
      |-> (sclk_o == clk_pol_i));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && ss_n_i) |-> !sdo_oe_o);

  assert_deselect_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_mode_i && $past(slave_mode_i) && $past(slave_mode_i, 2) && $past(slave_mode_i, 3)
     && ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) && $past(ss_n_i, 3)) |-> !busy_o);
endmodule

bind sync_serial_port ssp_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slave_mode_i (slave_mode_i),
  .clk_pol_i    (clk_pol_i),
  .ss_n_i       (ss_n_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .rx_data_o    (rx_data_o),
  .sclk_o       (sclk_o),
  .sdo_oe_o     (sdo_oe_o)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  localparam int H = 8;  // slave serial half-period in system cycles

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       slave_mode = 1'b0, clk_pol = 1'b0, phase = 1'b0, start = 1'b0;
  logic       sclk_in = 1'b0, ss_n = 1'b1, sdi = 1'b0;
  logic [7:0] div = 8'd2, tx_data = 8'h00;
  logic       busy, done, sclk_out, sdo, sdo_oe;
  logic [7:0] rx_data;

  int cyc = 0, checks = 0, errors = 0, done_cnt = 0, done_cyc = 0;
  bit finished = 0;

  sync_serial_port u_sync_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave_mode), .clk_pol_i(clk_pol),
    .phase_i(phase), .div_i(div), .start_i(start), .tx_data_i(tx_data),
    .busy_o(busy), .done_o(done), .rx_data_o(rx_data), .sclk_o(sclk_out),
    .sclk_i(sclk_in), .ss_n_i(ss_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdi_i(sdi)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && done) begin done_cnt++; done_cyc = cyc; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic master_xfer(input logic pol, input logic ph, input logic [7:0] dv,
                             input logic [7:0] tx, input logic [7:0] mb, input bit poke);
    int d, k, d0, tog;
    logic prev;
    logic [7:0] cap;
    string rp;
    d  = (dv < 2) ? 2 : int'(dv);
    rp = ph ? "R4" : "R5";
    @(negedge clk);
    slave_mode = 1'b0; clk_pol = pol; phase = ph; div = dv; tx_data = tx;
    sdi = ph ? mb[0] : 1'b0;
    repeat (3) @(negedge clk);
    check(sclk_out == pol, "R2 rest level before start", int'(sclk_out), int'(pol));
    d0 = done_cnt; k = 0; cap = '0; prev = pol;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= 16 * d + 3; t++) begin
      if (t > 0) @(negedge clk);
      if (poke && t == 3 * d) begin start = 1'b1; tx_data = ~tx; end
      if (poke && t == 3 * d + 1) start = 1'b0;
      tog = (t / d > 16) ? 16 : t / d;
      check(sclk_out == (pol ^ tog[0]), "R2 serial clock", int'(sclk_out), int'(pol ^ tog[0]));
      check(busy == (t <= 16 * d), "R6 busy window", int'(busy), int'(t <= 16 * d));
      check(done == (t == (ph ? 15 : 16) * d), "R6 done timing", int'(done),
            int'(t == (ph ? 15 : 16) * d));
      if (sclk_out != prev) begin
        if (prev == pol) begin  // leading edge
          if (ph) begin if (k < 8) cap[k] = sdo; end
          else if (k < 8) sdi = mb[k];
        end else begin          // trailing edge
          if (ph) begin k++; if (k < 8) sdi = mb[k]; end
          else begin if (k < 8) cap[k] = sdo; k++; end
        end
        prev = sclk_out;
      end
    end
    check(cap == tx, {rp, " R3 bits seen on sdo"}, int'(cap), int'(tx));
    check(rx_data == mb, {rp, " R3 byte received"}, int'(rx_data), int'(mb));
    check(done_cnt - d0 == 1, poke ? "R7 one done despite extra start" : "R6 one done",
          done_cnt - d0, 1);
  endtask

  task automatic slave_xfer(input logic pol, input logic ph, input logic [7:0] tx,
                            input logic [7:0] mb, input int nbits);
    int n, d0, last;
    string rp;
    rp = ph ? "R4" : "R5";
    @(negedge clk);
    slave_mode = 1'b1; clk_pol = pol; phase = ph; sclk_in = pol; ss_n = 1'b1;
    tx_data = tx; sdi = 1'b0;
    repeat (6) @(negedge clk);
    check(sdo_oe == 1'b0, "R8 released while deselected", int'(sdo_oe), 0);
    d0 = done_cnt; last = 0;
    ss_n = 1'b0; n = cyc;
    @(negedge clk);
    check(sdo_oe == 1'b1, "R8 driven when selected", int'(sdo_oe), 1);
    @(negedge clk);
    check(busy == 1'b0, "R9 busy not before third edge", int'(busy), 0);
    @(negedge clk);
    check(busy == 1'b1 && cyc == n + 3, "R9 busy on third edge", int'(busy), 1);
    repeat (3) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      if (b == nbits) break;
      if (ph) begin
        check(sdo == tx[b], {rp, " R3 slave bit before leading edge"}, int'(sdo), int'(tx[b]));
        sdi = mb[b]; sclk_in = ~pol; last = cyc;
        repeat (H) @(negedge clk);
        sclk_in = pol;
        repeat (H) @(negedge clk);
      end else begin
        sclk_in = ~pol; sdi = mb[b];
        repeat (H) @(negedge clk);
        check(sdo == tx[b], {rp, " R3 slave bit after leading edge"}, int'(sdo), int'(tx[b]));
        sclk_in = pol; last = cyc;
        repeat (H) @(negedge clk);
      end
    end
    if (nbits < 8) begin
      ss_n = 1'b1;
      repeat (6) @(negedge clk);
      check(busy == 1'b0, "R10 abort drops busy", int'(busy), 0);
      check(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
    end else begin
      check(done_cnt - d0 == 1, "R6 slave one done", done_cnt - d0, 1);
      check(done_cyc == last + 3, "R9 done three edges after last capture", done_cyc - last, 3);
      check(rx_data == mb, {rp, " R3 slave byte received"}, int'(rx_data), int'(mb));
      check(busy == 1'b0, "R6 slave idle after byte", int'(busy), 0);
      ss_n = 1'b1;
      @(negedge clk);
      check(sdo_oe == 1'b0, "R8 released after deselect", int'(sdo_oe), 0);
    end
  endtask

  task automatic deselected_clocks(input logic pol);
    int d0;
    logic [7:0] rx0;
    @(negedge clk);
    slave_mode = 1'b1; clk_pol = pol; sclk_in = pol; ss_n = 1'b1;
    repeat (4) @(negedge clk);
    d0 = done_cnt; rx0 = rx_data;
    for (int e = 0; e < 16; e++) begin
      sclk_in = ~sclk_in; sdi = ~sdi;
      repeat (H) @(negedge clk);
      check(busy == 1'b0, "R11 stays idle while deselected", int'(busy), 0);
    end
    check(done_cnt == d0, "R11 no done while deselected", done_cnt - d0, 0);
    check(rx_data == rx0, "R11 received byte untouched", int'(rx_data), int'(rx0));
    check(sdo_oe == 1'b0, "R8 released during stray clocks", int'(sdo_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1-hang actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(rx_data == 8'h00, "R1 rx after reset", int'(rx_data), 0);
    check(sclk_out == 1'b0, "R1 sclk after reset", int'(sclk_out), 0);

    master_xfer(1'b0, 1'b0, 8'd4, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b1, 1'b1, 8'd2, 8'h96, 8'hC3, 1'b0);
    master_xfer(1'b0, 1'b1, 8'd5, 8'h01, 8'h80, 1'b1);
    master_xfer(1'b1, 1'b0, 8'd1, 8'h7E, 8'h5A, 1'b0);

    slave_xfer(1'b0, 1'b0, 8'hB4, 8'h2D, 8);
    slave_xfer(1'b1, 1'b1, 8'h69, 8'hF0, 8);
    slave_xfer(1'b0, 1'b1, 8'h33, 8'hFF, 3);
    slave_xfer(1'b0, 1'b1, 8'hC5, 8'h1E, 8);
    slave_xfer(1'b1, 1'b0, 8'h0F, 8'hE1, 5);
    slave_xfer(1'b1, 1'b0, 8'h0F, 8'hE1, 8);
    deselected_clocks(1'b0);
    deselected_clocks(1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule